// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial line. Software writes a byte into a holding register. The transmitter copies the byte into its own shift register and then frames it on the line. A frame is one low start bit, eight data bits with the least significant bit first, an optional parity bit and one high stop bit. An external baud tick paces the frame: each bit lasts until the next single-cycle tick pulse.

The block keeps two flags. `hold_empty` says that the holding register can take another byte. `tx_done` says that the line has gone quiet. The transmitter looks at the holding register at the moment the stop bit begins. If a byte is waiting, that byte is loaded and its start bit follows the stop bit directly. If no byte is waiting, the done flag is set and the line stays at mark (1) after the stop bit. Each flag drives a level interrupt output, and each output has its own enable.

The state machine has five states:
- `ST_IDLE` is the mark line. It goes to `ST_START` when the holding register has data.
- `ST_START` sends the low bit. It goes to `ST_DATA` on a tick.
- `ST_DATA` shifts out the eight bits, one per tick. After the last bit it goes to `ST_PARITY` if parity is on, and to `ST_STOP` if parity is off.
- `ST_PARITY` goes to `ST_STOP` on a tick.
- `ST_STOP` goes on a tick to `ST_START` if a byte was chained, and to `ST_IDLE` if not.

The move into `ST_STOP` is the "stop entry" event, where the holding register is sampled.

Top module: `ser_tx_dbuf`

## Requirements
- R1: One cycle after a `wr_en` pulse, `hold_empty` is 0 and `tx_done` is 0.
- R2: In `ST_IDLE` with `hold_empty` at 0, the byte moves to the shift register in the next cycle. `hold_empty` returns to 1 and `tx_line` goes to 0 for the start bit.
- R3: `irq_txe` is 1 exactly when `hold_empty` is 1 and `txi_en` is 1, including while the line is idle.
- R4: A frame is a start bit of 0, then D0 to D7 in that order, then a stop bit of 1. Every bit after the start bit holds for exactly one baud-tick period.
- R5: With `par_en`=1, a parity bit follows D7. `par_odd`=0 gives even parity, so the ones in the data and parity bits add up to an even count. `par_odd`=1 gives an odd count. With `par_en`=0, the stop bit follows D7 directly.
- R6: If `hold_empty` is 0 at stop entry, that byte is loaded and `hold_empty` returns to 1. Its start bit follows the stop bit with no idle tick, and `tx_done` stays 0.
- R7: If `hold_empty` is 1 at stop entry, `tx_done` becomes 1. After the stop bit, `tx_line` stays at 1 until the next write.
- R8: `irq_tend` is 1 exactly when `tx_done` is 1 and `tei_en` is 1.
- R9: After reset, `tx_line`=1, `hold_empty`=1 and `tx_done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Single-cycle pulse that ends each bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| par_en | input | 1 | Static: insert a parity bit |
| par_odd | input | 1 | Static: 1 selects odd parity, 0 selects even parity |
| txi_en | input | 1 | Enable for the holding-register-empty interrupt |
| tei_en | input | 1 | Enable for the transmission-end interrupt |
| tx_line | output | 1 | Serial output, 1 when idle |
| hold_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmission ended, line idle |
| irq_txe | output | 1 | Holding-register-empty interrupt request |
| irq_tend | output | 1 | Transmission-end interrupt request |

## Verification
The bench decodes the line at every tick and uses four kinds of input pattern:
- **Single bytes, for each parity setting.** These separate the bit order, the parity polarity and the frame length.
- **A stream of three bytes**, each written while the previous frame is still on the line. This checks that the stop-time sample chains frames with no idle tick.
- **Two bytes separated by a pause.** This must show idle ticks and a set done flag, which tells the park-in-mark path apart from the chaining path.
- **Interrupt enables switched off.** Here the flags still move while the interrupt outputs stay low.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } txst_e;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          xfer,
    input  logic          set_end,
    output logic [DW-1:0] hold_q,
    output logic          empty_q,
    output logic          end_q
);

    // A CPU write has priority over a transfer in the same cycle.
    // The shifter takes the old contents, and the new byte stays pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
            end_q   <= 1'b1;
        end else begin
            if (wr_en) begin
                hold_q  <= wr_data;
                empty_q <= 1'b0;
            end else if (xfer) begin
                empty_q <= 1'b1;
            end

            if (wr_en) begin
                end_q <= 1'b0;
            end else if (set_end) begin
                end_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          shift,
    input  logic          par_odd,
    output logic          out_bit,
    output logic          par_bit,
    output logic          last_bit
);

    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [DW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic          par_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= load_data;
            cnt_q <= '0;
            par_q <= (^load_data) ^ par_odd;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign out_bit  = sh_q[0];
    assign par_bit  = par_q;
    assign last_bit = (cnt_q == LAST);

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  empty,
    input  logic  last_bit,
    input  logic  par_en,
    input  logic  out_bit,
    input  logic  par_bit,
    output logic  xfer,
    output logic  shift,
    output logic  set_end,
    output logic  line,
    output txst_e st
);

    txst_e st_nxt;
    logic  chain_q;
    logic  stop_enter;

    // next state and per-cycle strobes
    always_comb begin
        st_nxt     = st;
        xfer       = 1'b0;
        shift      = 1'b0;
        stop_enter = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!empty) begin
                    xfer   = 1'b1;
                    st_nxt = ST_START;
                end
            end
            ST_START: begin
                if (tick) st_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (tick) begin
                    shift = 1'b1;
                    if (last_bit) begin
                        if (par_en) begin
                            st_nxt = ST_PARITY;
                        end else begin
                            st_nxt     = ST_STOP;
                            stop_enter = 1'b1;
                        end
                    end
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    st_nxt     = ST_STOP;
                    stop_enter = 1'b1;
                end
            end
            ST_STOP: begin
                if (tick) st_nxt = chain_q ? ST_START : ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
        // holding register sampled as the stop bit begins
        if (stop_enter && !empty) xfer = 1'b1;
        set_end = stop_enter && empty;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            chain_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (stop_enter) chain_q <= !empty;
        end
    end

    // line output
    always_comb begin
        unique case (st)
            ST_START:  line = 1'b0;
            ST_DATA:   line = out_bit;
            ST_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
    import sertx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          txi_en,
    input  logic          tei_en,
    output logic          tx_line,
    output logic          hold_empty,
    output logic          tx_done,
    output logic          irq_txe,
    output logic          irq_tend
);

    logic [DW-1:0] hold_w;
    logic          xfer_w;
    logic          shift_w;
    logic          set_end_w;
    logic          out_bit_w;
    logic          par_bit_w;
    logic          last_w;
    txst_e         st_w;

    sertx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .xfer    (xfer_w),
        .set_end (set_end_w),
        .hold_q  (hold_w),
        .empty_q (hold_empty),
        .end_q   (tx_done)
    );

    sertx_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (xfer_w),
        .load_data (hold_w),
        .shift     (shift_w),
        .par_odd   (par_odd),
        .out_bit   (out_bit_w),
        .par_bit   (par_bit_w),
        .last_bit  (last_w)
    );

    sertx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .empty    (hold_empty),
        .last_bit (last_w),
        .par_en   (par_en),
        .out_bit  (out_bit_w),
        .par_bit  (par_bit_w),
        .xfer     (xfer_w),
        .shift    (shift_w),
        .set_end  (set_end_w),
        .line     (tx_line),
        .st       (st_w)
    );

    assign irq_txe  = hold_empty & txi_en;
    assign irq_tend = tx_done & tei_en;

endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk
    import sertx_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  baud_tick,
    input logic  wr_en,
    input logic  txi_en,
    input logic  tei_en,
    input logic  tx_line,
    input logic  hold_empty,
    input logic  tx_done,
    input logic  irq_txe,
    input logic  irq_tend,
    input txst_e st
);

    assert_write_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!hold_empty && !tx_done));

    assert_empty_falls_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && $past(hold_empty)) |-> $past(wr_en));

    assert_txe_on_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_empty) && txi_en) |-> irq_txe);

    assert_bit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && $past(st) == ST_DATA && !$past(baud_tick)) |-> $stable(tx_line));

    assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> tx_line);

    assert_done_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (st == ST_STOP));

    assert_tend_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tei_en |-> !irq_tend);

endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .txi_en     (txi_en),
    .tei_en     (tei_en),
    .tx_line    (tx_line),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .irq_txe    (irq_txe),
    .irq_tend   (irq_tend),
    .st         (st_w)
);

// File: tb/ser_tx_dbuf_tb.sv
`timescale 1ns/1ps
module ser_tx_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       txi_en = 1'b1;
    logic       tei_en = 1'b1;
    logic       tx_line, hold_empty, tx_done, irq_txe, irq_tend;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    ser_tx_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .par_en(par_en), .par_odd(par_odd),
        .txi_en(txi_en), .tei_en(tei_en), .tx_line(tx_line),
        .hold_empty(hold_empty), .tx_done(tx_done),
        .irq_txe(irq_txe), .irq_tend(irq_tend)
    );

    // baud tick: one cycle high every 8 cycles
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % 8;
            baud_tick = (c == 0);
        end
    end

    // line decoder, one sample per tick
    int         rx_n = 0;
    logic [7:0] rx_byte [0:15];
    logic       rx_par  [0:15];
    logic       rx_stop [0:15];
    int         rx_gap  [0:15];
    initial begin
        int ph = 0;
        int gap = 0;
        logic [7:0] sb = '0;
        logic pb = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && baud_tick) begin
                if (ph == 0) begin
                    if (!tx_line) ph = 1; else gap++;
                end else if (ph <= 8) begin
                    sb[ph-1] = tx_line;
                    ph++;
                    if (ph == 9 && !par_en) ph = 10;
                end else if (ph == 9) begin
                    pb = tx_line;
                    ph = 10;
                end else begin
                    if (rx_n < 16) begin
                        rx_byte[rx_n] = sb;
                        rx_par[rx_n]  = pb;
                        rx_stop[rx_n] = tx_line;
                        rx_gap[rx_n]  = gap;
                    end
                    rx_n++;
                    gap = 0;
                    ph  = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rx(input int target);
        for (int i = 0; i < 5000; i++) begin
            if (rx_n >= target) break;
            @(negedge clk);
        end
        check("R4 frame arrival", (rx_n >= target) ? 1 : 0, 1);
    endtask

    task automatic t_reset();
        check("R9 line", int'(tx_line), 1);
        check("R9 empty", int'(hold_empty), 1);
        check("R9 done", int'(tx_done), 1);
        check("R3 idle irq_txe", int'(irq_txe), 1);
        check("R8 idle irq_tend", int'(irq_tend), 1);
    endtask

    task automatic t_single(input logic [7:0] b, input logic pe, input logic po);
        int n0;
        logic exp_p;
        par_en = pe;
        par_odd = po;
        n0 = rx_n;
        send(b);
        check("R1 empty after write", int'(hold_empty), 0);
        check("R1 done after write", int'(tx_done), 0);
        check("R8 tend low", int'(irq_tend), 0);
        @(negedge clk);
        check("R2 empty back", int'(hold_empty), 1);
        check("R2 start bit", int'(tx_line), 0);
        wait_rx(n0 + 1);
        check("R4 data", int'(rx_byte[n0]), int'(b));
        check("R4 stop", int'(rx_stop[n0]), 1);
        if (pe) begin
            exp_p = (^b) ^ po;
            check("R5 parity", int'(rx_par[n0]), int'(exp_p));
        end
        check("R7 done", int'(tx_done), 1);
        check("R8 tend", int'(irq_tend), 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!tx_line) check("R7 mark hold", 0, 1);
        end
        check("R7 mark line", int'(tx_line), 1);
    endtask

    task automatic t_stream();
        int n0;
        par_en = 1'b0;
        n0 = rx_n;
        send(8'h3C);
        repeat (2) @(negedge clk);
        send(8'hA7);
        check("R3 busy empty low", int'(hold_empty), 0);
        check("R3 busy irq_txe", int'(irq_txe), 0);
        for (int i = 0; i < 500; i++) begin
            if (hold_empty) break;
            @(negedge clk);
        end
        check("R6 chained load", int'(hold_empty), 1);
        check("R6 done low", int'(tx_done), 0);
        send(8'h01);
        wait_rx(n0 + 2);
        check("R6 done during chain", int'(tx_done), 0);
        wait_rx(n0 + 3);
        check("R4 stream b0", int'(rx_byte[n0]), 8'h3C);
        check("R4 stream b1", int'(rx_byte[n0+1]), 8'hA7);
        check("R4 stream b2", int'(rx_byte[n0+2]), 8'h01);
        check("R6 gap1", rx_gap[n0+1], 0);
        check("R6 gap2", rx_gap[n0+2], 0);
        check("R7 stream end", int'(tx_done), 1);
    endtask

    task automatic t_pause();
        int n0;
        n0 = rx_n;
        send(8'h55);
        wait_rx(n0 + 1);
        repeat (30) @(negedge clk);
        send(8'hAA);
        wait_rx(n0 + 2);
        check("R7 idle gap", (rx_gap[n0+1] > 0) ? 1 : 0, 1);
        check("R4 pause b1", int'(rx_byte[n0+1]), 8'hAA);
    endtask

    task automatic t_mask();
        txi_en = 1'b0;
        tei_en = 1'b0;
        @(negedge clk);
        check("R3 masked txe", int'(irq_txe), 0);
        check("R8 masked tend", int'(irq_tend), 0);
        check("R3 flag kept", int'(hold_empty), 1);
        txi_en = 1'b1;
        tei_en = 1'b1;
        @(negedge clk);
        check("R3 unmasked txe", int'(irq_txe), 1);
        check("R8 unmasked tend", int'(irq_tend), 1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(8'hB5, 1'b0, 1'b0);
        t_single(8'h96, 1'b1, 1'b0);
        t_single(8'h96, 1'b1, 1'b1);
        t_single(8'h07, 1'b1, 1'b0);
        t_stream();
        t_pause();
        t_mask();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule